// File: doc/BRIEF.md
# DMA Event Status and Interrupt Unit

This unit keeps the status of a transmit DMA channel and a receive DMA channel and turns it into one level-sensitive interrupt line. Each channel has an 8-bit count of completed packets, a packet-done flag and an error flag. The error flag marks a transmit underrun or a receive overflow. The DMA engines signal events with single-cycle pulses. Software reads the status words and acknowledges events by writing ones to them. Acknowledging a done flag removes one packet from the count. The flag stays set until the count has drained to zero.

An 8-bit mask selects which pending bits reach the interrupt line. A read-only interrupt word shows the masked pending bits. The unit also holds the receive DMA enable bit, which a receive overflow turns off. Software uses a simple 32-bit port with a word address, a write strobe and write data. Read data is combinational from the address.

Top module: `dma_event_status`

## Requirements
- R1: After reset every count, flag, the mask and the receive enable are zero, `irq` is low, and every address reads zero.
- R2: A done pulse on a channel raises the count in status bits 23:16 by one and sets status bit 0. The transmit status is at address 0 and the receive status is at address 1.
- R3: Writing a word with bit 0 set to a status address lowers that count by one, and by nothing when it is already zero. Bit 0 clears only if the count is zero after the write.
- R4: The count holds at 255 when a done pulse arrives at 255.
- R5: A done pulse and an acknowledge of the same channel in the same cycle leave the count unchanged and bit 0 set.
- R6: The transmit underrun flag is status bit 1 and the receive overflow flag is status bit 2. An error pulse sets the flag, and writing 1 to that bit clears it. A pulse in the same cycle as the clearing write wins.
- R7: The receive enable is bit 0 at address 2 and is written directly. A receive overflow pulse clears it, and takes priority over a write in the same cycle.
- R8: The pending vector places receive status bits 3:0 in bits 7:4 and transmit status bits 3:0 in bits 3:0. The mask is bits 7:0 at address 3. Address 4 reads the mask ANDed with the pending vector in bits 7:0.
- R9: `irq` is high exactly when the masked pending value is non-zero.
- R10: Writes to address 4 change nothing. A status write with zero in bits 0 and in the error bit has no effect. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr` |
| tx_done_evt | input | 1 | Transmit packet-done pulse |
| tx_underrun_evt | input | 1 | Transmit underrun pulse |
| rx_done_evt | input | 1 | Receive packet-done pulse |
| rx_overflow_evt | input | 1 | Receive overflow pulse |
| rx_dma_en | output | 1 | Receive DMA enable |
| irq | output | 1 | Interrupt request |

## Verification
Every event pulse and register write takes effect at the first rising edge that samples it. The counts, the flags, the enable, the mask and therefore `irq` all change exactly one edge after the stimulus. Read data follows the address with no clock, so a status word, the interrupt word and `irq` can all be checked in the same cycle as the update. The bench drives each stimulus on the falling edge. It updates its model at the next rising edge, and 1 ns later it sweeps every address with the write strobe low, so each check sees the state exactly one edge after its cause.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int CNT_W      = 8;
    localparam int CNT_LSB    = 16;
    localparam int DONE_BIT   = 0;
    localparam int TX_ERR_BIT = 1;
    localparam int RX_ERR_BIT = 2;
    localparam int PEND_W     = 4;
    localparam int MASK_W     = 2 * PEND_W;

    localparam logic [ADDR_W-1:0] A_TX_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_RX_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_RX_CTL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK    = 3'd3;
    localparam logic [ADDR_W-1:0] A_IRQ     = 3'd4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
    } chan_st_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              rx_en;
    } top_st_t;
endpackage

// File: rtl/dma_stat_chan.sv
module dma_stat_chan
    import dma_stat_pkg::*;
#(
    parameter int ERR_BIT = TX_ERR_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_evt,
    input  logic              err_evt,
    input  logic              sel_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] status
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    chan_st_t st_d, st_q;
    logic     ack, err_clr;
    logic     unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        ack     = sel_wr & wr_data[DONE_BIT];
        err_clr = sel_wr & wr_data[ERR_BIT];
        st_d    = st_q;
        if (done_evt && !ack) begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (ack && !done_evt) begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        end
        if (done_evt)   st_d.done = 1'b1;
        else if (ack)   st_d.done = (st_d.cnt != '0);
        if (err_evt)      st_d.err = 1'b1;
        else if (err_clr) st_d.err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status                   = '0;
        status[CNT_LSB +: CNT_W] = st_q.cnt;
        status[DONE_BIT]         = st_q.done;
        status[ERR_BIT]          = st_q.err;
    end

    p_done_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> st_q.done);
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !ack && st_q.cnt != CNT_MAX) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !done_evt && st_q.cnt == '0) |=> (st_q.cnt == '0) && !st_q.done);
    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && st_q.cnt == CNT_MAX) |=> st_q.cnt == CNT_MAX);
    p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && ack) |=> ($stable(st_q.cnt) && st_q.done));
    p_err_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> st_q.err);
endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq #(
    parameter int PEND_W = 4
) (
    input  logic [PEND_W-1:0]   tx_bits,
    input  logic [PEND_W-1:0]   rx_bits,
    input  logic [2*PEND_W-1:0] mask,
    output logic [2*PEND_W-1:0] masked,
    output logic                irq
);
    always_comb begin
        masked = mask & {rx_bits, tx_bits};
        irq    = |masked;
    end
endmodule

// File: rtl/dma_event_status.sv
module dma_event_status
    import dma_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_done_evt,
    input  logic              tx_underrun_evt,
    input  logic              rx_done_evt,
    input  logic              rx_overflow_evt,
    output logic              rx_dma_en,
    output logic              irq
);
    localparam int NCH = 2;

    logic [NCH-1:0]    done_v, err_v, sel_v;
    logic [DATA_W-1:0] stat [NCH];
    logic [MASK_W-1:0] masked;
    top_st_t           st_d, st_q;

    assign done_v = {rx_done_evt, tx_done_evt};
    assign err_v  = {rx_overflow_evt, tx_underrun_evt};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [ADDR_W-1:0] MY_ADDR = (g == 0) ? A_TX_STAT : A_RX_STAT;
        assign sel_v[g] = wr_en && (reg_addr == MY_ADDR);
        dma_stat_chan #(
            .ERR_BIT((g == 0) ? TX_ERR_BIT : RX_ERR_BIT)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .done_evt (done_v[g]),
            .err_evt  (err_v[g]),
            .sel_wr   (sel_v[g]),
            .wr_data  (wr_data),
            .status   (stat[g])
        );
    end

    dma_stat_irq #(.PEND_W(PEND_W)) u_irq (
        .tx_bits (stat[0][PEND_W-1:0]),
        .rx_bits (stat[1][PEND_W-1:0]),
        .mask    (st_q.mask),
        .masked  (masked),
        .irq     (irq)
    );

    always_comb begin
        st_d = st_q;
        if (rx_overflow_evt)
            st_d.rx_en = 1'b0;
        else if (wr_en && reg_addr == A_RX_CTL)
            st_d.rx_en = wr_data[0];
        if (wr_en && reg_addr == A_MASK)
            st_d.mask = wr_data[MASK_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_dma_en = st_q.rx_en;

    always_comb begin
        rd_data = '0;
        case (reg_addr)
            A_TX_STAT: rd_data = stat[0];
            A_RX_STAT: rd_data = stat[1];
            A_RX_CTL:  rd_data[0] = st_q.rx_en;
            A_MASK:    rd_data[MASK_W-1:0] = st_q.mask;
            A_IRQ:     rd_data[MASK_W-1:0] = masked;
            default:   rd_data = '0;
        endcase
    end

    p_ovf_drops_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow_evt |=> !rx_dma_en);
    p_irq_masked_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq);
    p_irq_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat[0][PEND_W-1:0] | stat[1][PEND_W-1:0]) != '0));
    p_irq_reg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == A_IRQ && !tx_done_evt && !rx_done_evt
         && !tx_underrun_evt && !rx_overflow_evt) |=> $stable(irq));
endmodule

// File: tb/dma_event_status_test.sv
`timescale 1ns/1ps
module dma_event_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tx_done_evt = 1'b0, tx_underrun_evt = 1'b0;
    logic        rx_done_evt = 1'b0, rx_overflow_evt = 1'b0;
    logic        rx_dma_en, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int       m_cnt [2];
    bit       m_done [2];
    bit       m_err [2];
    bit       m_en;
    bit [7:0] m_mask;

    always #2.5 clk = ~clk;

    dma_event_status uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .tx_done_evt(tx_done_evt), .tx_underrun_evt(tx_underrun_evt),
        .rx_done_evt(rx_done_evt), .rx_overflow_evt(rx_overflow_evt),
        .rx_dma_en(rx_dma_en), .irq(irq)
    );

    function automatic logic [31:0] stat_word(int ch);
        logic [31:0] w = '0;
        w[23:16] = 8'(m_cnt[ch]);
        w[0]     = m_done[ch];
        w[ch == 0 ? 1 : 2] = m_err[ch];
        return w;
    endfunction

    function automatic logic [7:0] pend_vec();
        logic [31:0] t = stat_word(0);
        logic [31:0] r = stat_word(1);
        return {r[3:0], t[3:0]};
    endfunction

    function automatic logic [31:0] exp_read(int a);
        case (a)
            0: return stat_word(0);
            1: return stat_word(1);
            2: return {31'b0, m_en};
            3: return {24'b0, m_mask};
            4: return {24'b0, m_mask & pend_vec()};
            default: return 32'b0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #0.1;
            chk(rd_data, exp_read(a), $sformatf("%s addr%0d", tag, a));
        end
        chk({31'b0, irq}, {31'b0, |(m_mask & pend_vec())}, {tag, " R9 irq"});
        chk({31'b0, rx_dma_en}, {31'b0, m_en}, {tag, " R7 rx_dma_en"});
    endtask

    task automatic model(input bit td, tu, rd, ro, we, input int a, input logic [31:0] d);
        bit dn [2];
        bit er [2];
        dn[0] = td; dn[1] = rd; er[0] = tu; er[1] = ro;
        for (int ch = 0; ch < 2; ch++) begin
            bit ack = we && a == ch && d[0];
            bit clr = we && a == ch && d[ch == 0 ? 1 : 2];
            if (dn[ch] && !ack) m_cnt[ch] = (m_cnt[ch] == 255) ? 255 : m_cnt[ch] + 1;
            else if (ack && !dn[ch]) m_cnt[ch] = (m_cnt[ch] == 0) ? 0 : m_cnt[ch] - 1;
            if (dn[ch]) m_done[ch] = 1;
            else if (ack) m_done[ch] = (m_cnt[ch] != 0);
            if (er[ch]) m_err[ch] = 1;
            else if (clr) m_err[ch] = 0;
        end
        if (ro) m_en = 0;
        else if (we && a == 2) m_en = d[0];
        if (we && a == 3) m_mask = d[7:0];
    endtask

    task automatic step(input bit td, tu, rd, ro, we, input int a,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        tx_done_evt = td; tx_underrun_evt = tu; rx_done_evt = rd; rx_overflow_evt = ro;
        wr_en = we; reg_addr = 3'(a); wr_data = d;
        @(posedge clk);
        model(td, tu, rd, ro, we, a, d);
        #1;
        tx_done_evt = 0; tx_underrun_evt = 0; rx_done_evt = 0; rx_overflow_evt = 0;
        wr_en = 0;
        check_all(tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        for (int ch = 0; ch < 2; ch++) begin m_cnt[ch] = 0; m_done[ch] = 0; m_err[ch] = 0; end
        m_en = 0; m_mask = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0.5 check_all("R1 reset");

        // R2 and R3: count up three, drain three, extra ack at zero
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, "R2 tx done");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 32'h1, "R3 tx ack");
        step(0, 0, 0, 0, 1, 0, 32'h1, "R3 ack at zero");
        for (int i = 0; i < 2; i++) step(0, 0, 1, 0, 0, 0, 0, "R2 rx done");
        step(0, 0, 0, 0, 1, 1, 32'h1, "R3 rx ack partial");
        // R5 same-cycle increment and acknowledge
        step(1, 0, 1, 0, 1, 1, 32'h1, "R5 rx both");
        step(1, 0, 0, 0, 1, 0, 32'h1, "R5 tx both from zero");
        // R4 saturation
        for (int i = 0; i < 258; i++) step(1, 0, 0, 0, 0, 0, 0, "R4 saturate");
        // R6 error flags
        step(0, 1, 0, 1, 0, 0, 0, "R6 set errors");
        step(0, 0, 0, 0, 1, 0, 32'h2, "R6 clear underrun");
        step(0, 1, 0, 0, 1, 0, 32'h2, "R6 set beats clear");
        step(0, 0, 0, 0, 1, 1, 32'h4, "R6 clear overflow");
        // R10 writes with no ack bits, writes to interrupt word
        step(0, 0, 0, 0, 1, 0, 32'hFFFF_FFF8, "R10 no-op status write");
        step(0, 0, 0, 0, 1, 4, 32'hFFFF_FFFF, "R10 irq write ignored");
        // R7 receive enable
        step(0, 0, 0, 0, 1, 2, 32'h1, "R7 enable");
        step(0, 0, 0, 1, 0, 0, 0, "R7 overflow clears");
        step(0, 0, 0, 0, 1, 2, 32'h1, "R7 re-enable");
        step(0, 0, 0, 1, 1, 2, 32'h1, "R7 overflow beats write");
        // R8 and R9 mask
        step(0, 0, 0, 0, 1, 3, 32'h0000_0040, "R8 mask rx overflow");
        step(0, 0, 0, 0, 1, 3, 32'h0000_0008, "R9 mask unused bit");
        step(0, 0, 0, 0, 1, 3, 32'h0000_00FF, "R8 mask all");

        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            bit td = ($urandom % 3) == 0;
            bit tu = ($urandom % 16) == 0;
            bit rd = ($urandom % 3) == 0;
            bit ro = ($urandom % 20) == 0;
            bit we = ($urandom % 2) == 0;
            int a  = $urandom % 8;
            logic [31:0] d = $urandom;
            step(td, tu, rd, ro, we, a, d, "R2 R3 R6 R8 random");
        end
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule